// File: doc/BRIEF.md
# Programmable Occupancy Threshold Flags for a Dual-Clock FIFO

This unit produces two active-low warning flags for a FIFO whose write and read sides run on independent clocks. The "nearly empty" flag goes low when the number of stored words is at or below one threshold. The "nearly full" flag goes low when the number of free slots is at or below a second threshold. The FIFO supplies its binary write count, which is advanced on the write clock, and its binary read count, which is advanced on the read clock. The unit carries each count into the other clock domain with a Gray-coded two-stage synchronizer, so each flag can be computed locally.

Both thresholds start from one of eight preset values, chosen by a 3-bit select that is sampled during master reset. Either threshold can then be rewritten on the write clock while the load strobe is high, in one of two ways:
- Parallel: one 18-bit word per threshold, or two 9-bit words per threshold.
- Serial: one bit per clock.

A sequencer decides which threshold, and which half of it, the next load writes. Its states are:
- `SEQ_AE_LO`: low part of the empty threshold, or all of it for 18-bit words.
- `SEQ_AE_HI`: high part of the empty threshold, used for 9-bit words only.
- `SEQ_AF_LO`: low part of the full threshold, or all of it for 18-bit words.
- `SEQ_AF_HI`: high part of the full threshold, used for 9-bit words only.

With 18-bit words the sequencer moves AE_LO→AF_LO→AE_LO. With 9-bit words it moves AE_LO→AE_HI→AF_LO→AF_HI→AE_LO. A serial load moves from the empty region to AF_LO after the last bit of the empty threshold, and from the full region back to AE_LO after the last bit of the full threshold. Whenever the load strobe is low, the sequencer returns to AE_LO.

The following are also sampled during master reset:
- the timing mode, synchronous or asynchronous, shared by both flags;
- the input word width;
- the parity-stripping mode.

Top module: `pflag_unit`

## Requirements
- R1: Master reset (`mrst`=1) loads both thresholds with the preset value (8<<`cfg_dflt_sel`)−1: 7, 15, 31, 63, 127, 255, 511 or 1023. While the FIFO is empty after reset, `ae_n`=0 and `af_n`=1.
- R2: `ae_n` is 0 when the occupancy (write count − read count) is at or below the empty threshold, and 1 otherwise.
- R3: `af_n` is 0 when the free space (DEPTH − occupancy) is at or below the full threshold, and 1 otherwise.
- R4: In synchronous mode (`cfg_sync_flags`=1 at reset), `ae_n` is a register clocked by `rclk` that uses the synchronized write count, and `af_n` is a register clocked by `wclk` that uses the synchronized read count. A change of a count does not reach either flag before a clock edge.
- R5: In asynchronous mode (`cfg_sync_flags`=0 at reset), both flags follow the two counts combinationally. A read-side change of `rd_count` moves the flags at once, and so does a write-side change of `wr_count`.
- R6: For an 18-bit parallel load with parity stripping (`cfg_par_strip`=1), the threshold is the low OFS_W bits of {`prog_data`[17:9], `prog_data`[7:0]}. Bit 8 is ignored.
- R7: For an 18-bit parallel load without parity stripping, the threshold is `prog_data`[OFS_W−1:0] (bit 8 included). Bits 16 and 17 are ignored.
- R8: With 9-bit input (`cfg_narrow_in`=1), each threshold takes two loads: bits [8:0] first, then bits [OFS_W−1:9] from `prog_data`[OFS_W−10:0]. `prog_data`[17:9] is ignored, and parity stripping has no effect.
- R9: A parallel load happens on a `wclk` edge with `prog_ld`=1 and `prog_wen`=1. Loads fill the empty threshold first and then the full threshold. Any cycle with `prog_ld`=0 returns the sequence to the start of the empty threshold.
- R10: A serial load happens on a `wclk` edge with `prog_ld`=1, `prog_sen`=1 and `prog_wen`=0. It writes `prog_sdata` LSB first: OFS_W bits into the empty threshold, then OFS_W bits into the full threshold.
- R11: Partial reset (`prst`=1) keeps both thresholds and all reset-time modes. It returns the flags and the load sequence to their reset state.
- R12: The timing mode, width and parity pins are sampled only during master reset. Changing them later has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, active high; `wclk` must run while it is held |
| prst | input | 1 | Partial reset, active high |
| cfg_sync_flags | input | 1 | Timing mode sampled at master reset: 1 = synchronous, 0 = asynchronous |
| cfg_narrow_in | input | 1 | Input width sampled at master reset: 1 = 9-bit, 0 = 18-bit |
| cfg_par_strip | input | 1 | Parity stripping sampled at master reset: 1 = drop bit 8 of 18-bit loads |
| cfg_dflt_sel | input | 3 | Preset threshold code sampled at master reset |
| prog_ld | input | 1 | Threshold load strobe |
| prog_wen | input | 1 | Parallel load enable |
| prog_sen | input | 1 | Serial load enable |
| prog_sdata | input | 1 | Serial load bit |
| prog_data | input | 18 | Parallel load word |
| wr_count | input | AW+1 | Binary write count, `wclk` domain |
| rd_count | input | AW+1 | Binary read count, `rclk` domain |
| ae_n | output | 1 | Nearly-empty flag, active low |
| af_n | output | 1 | Nearly-full flag, active low |

## Verification
The bench probes each threshold exactly at its boundary count and one count beyond it. A comparison of `<` where `<=` belongs shows up as a flag that is off by one word.

Loads deliberately carry ones in bit 8 and in bits 16–17:
- A design that strips the wrong bit, or skips stripping, yields a threshold 256 away from the expected one.
- A 9-bit load that takes the upper data bits puts the flag edge hundreds of words off.

A load session is broken and restarted, which catches a sequencer that fails to return to the empty threshold: that design swaps the two thresholds. Timing is checked one nanosecond after a count change:
- A synchronous flag that moves at that point is wrongly combinational.
- An asynchronous flag that has not moved is wrongly registered.
- A mode pin toggled after reset must change neither behaviour.

// File: rtl/pflag_pkg.sv
package pflag_pkg;

    localparam int LOAD_W = 18;
    localparam int BYTE_W = 9;

    typedef enum logic [1:0] {
        SEQ_AE_LO = 2'd0,
        SEQ_AE_HI = 2'd1,
        SEQ_AF_LO = 2'd2,
        SEQ_AF_HI = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic sync_mode;
        logic narrow_in;
        logic par_strip;
    } pflag_cfg_t;

    function automatic logic [31:0] preset_offset(input logic [2:0] sel);
        return (32'd8 << sel) - 32'd1;
    endfunction

endpackage

// File: rtl/pflag_count_sync.sv
module pflag_count_sync #(
    parameter int PW = 11
) (
    input  logic          src_clk,
    input  logic          dst_clk,
    input  logic          rst,
    input  logic [PW-1:0] src_count,
    output logic [PW-1:0] dst_count
);

    logic [PW-1:0] gray_src;
    logic [PW-1:0] gray_meta;
    logic [PW-1:0] gray_dst;

    always_ff @(posedge src_clk or posedge rst) begin
        if (rst) begin
            gray_src <= '0;
        end else begin
            gray_src <= src_count ^ (src_count >> 1);
        end
    end

    always_ff @(posedge dst_clk or posedge rst) begin
        if (rst) begin
            gray_meta <= '0;
            gray_dst  <= '0;
        end else begin
            gray_meta <= gray_src;
            gray_dst  <= gray_meta;
        end
    end

    always_comb begin
        dst_count[PW-1] = gray_dst[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            dst_count[i] = dst_count[i+1] ^ gray_dst[i];
        end
    end

endmodule

// File: rtl/pflag_offset_prog.sv
module pflag_offset_prog
    import pflag_pkg::*;
#(
    parameter int OFS_W = 10
) (
    input  logic                wclk,
    input  logic                mrst,
    input  logic                prst,
    input  pflag_cfg_t          cfg_pins,
    input  logic [2:0]          dflt_sel,
    input  logic                ld,
    input  logic                wen,
    input  logic                sen,
    input  logic                sdata,
    input  logic [LOAD_W-1:0]   pdata,
    output pflag_cfg_t          cfg_q,
    output logic [OFS_W-1:0]    ae_ofs,
    output logic [OFS_W-1:0]    af_ofs,
    output seq_state_e          seq_q
);

    localparam int HI_W  = OFS_W - BYTE_W;
    localparam int CNT_W = $clog2(OFS_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(OFS_W - 1);

    seq_state_e       seq_d;
    logic [CNT_W-1:0] bit_q;
    logic [CNT_W-1:0] bit_d;
    logic             seq_rst;
    logic             par_wr;
    logic             ser_wr;
    logic             ser_last;
    logic             in_ae_region;
    logic [16:0]      stripped_word;
    logic [OFS_W-1:0] wide_value;
    logic [OFS_W-1:0] preset_value;

    assign seq_rst      = mrst | prst;
    assign par_wr       = ld & wen & ~prst;
    assign ser_wr       = ld & sen & ~wen & ~prst;
    assign ser_last     = (bit_q == LAST_BIT);
    assign in_ae_region = (seq_q == SEQ_AE_LO) || (seq_q == SEQ_AE_HI);
    assign preset_value = OFS_W'(preset_offset(dflt_sel));

    // 18-bit word to threshold, with or without parity stripping
    always_comb begin
        stripped_word = {pdata[17:9], pdata[7:0]};
        if (cfg_q.par_strip) begin
            wide_value = stripped_word[OFS_W-1:0];
        end else begin
            wide_value = pdata[OFS_W-1:0];
        end
    end

    // sequencer state register
    always_ff @(posedge wclk or posedge seq_rst) begin
        if (seq_rst) begin
            seq_q <= SEQ_AE_LO;
            bit_q <= '0;
        end else begin
            seq_q <= seq_d;
            bit_q <= bit_d;
        end
    end

    // sequencer next state
    always_comb begin
        seq_d = seq_q;
        bit_d = bit_q;
        if (!ld) begin
            seq_d = SEQ_AE_LO;
            bit_d = '0;
        end else if (par_wr) begin
            bit_d = '0;
            unique case (seq_q)
                SEQ_AE_LO: seq_d = cfg_q.narrow_in ? SEQ_AE_HI : SEQ_AF_LO;
                SEQ_AE_HI: seq_d = SEQ_AF_LO;
                SEQ_AF_LO: seq_d = cfg_q.narrow_in ? SEQ_AF_HI : SEQ_AE_LO;
                SEQ_AF_HI: seq_d = SEQ_AE_LO;
            endcase
        end else if (ser_wr) begin
            if (ser_last) begin
                bit_d = '0;
                seq_d = in_ae_region ? SEQ_AF_LO : SEQ_AE_LO;
            end else begin
                bit_d = bit_q + 1'b1;
            end
        end
    end

    // threshold registers and reset-time configuration
    always_ff @(posedge wclk) begin
        if (mrst) begin
            cfg_q  <= cfg_pins;
            ae_ofs <= preset_value;
            af_ofs <= preset_value;
        end else if (par_wr) begin
            unique case (seq_q)
                SEQ_AE_LO: begin
                    if (cfg_q.narrow_in) begin
                        ae_ofs[BYTE_W-1:0] <= pdata[BYTE_W-1:0];
                    end else begin
                        ae_ofs <= wide_value;
                    end
                end
                SEQ_AE_HI: ae_ofs[OFS_W-1:BYTE_W] <= pdata[HI_W-1:0];
                SEQ_AF_LO: begin
                    if (cfg_q.narrow_in) begin
                        af_ofs[BYTE_W-1:0] <= pdata[BYTE_W-1:0];
                    end else begin
                        af_ofs <= wide_value;
                    end
                end
                SEQ_AF_HI: af_ofs[OFS_W-1:BYTE_W] <= pdata[HI_W-1:0];
            endcase
        end else if (ser_wr) begin
            if (in_ae_region) begin
                ae_ofs[bit_q] <= sdata;
            end else begin
                af_ofs[bit_q] <= sdata;
            end
        end
    end

endmodule

// File: rtl/pflag_flag_gen.sv
module pflag_flag_gen #(
    parameter int PW    = 11,
    parameter int OFS_W = 10,
    parameter int DEPTH = 1024
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             rst,
    input  logic             sync_mode,
    input  logic [PW-1:0]    wr_count,
    input  logic [PW-1:0]    rd_count,
    input  logic [PW-1:0]    wr_cnt_rs,
    input  logic [PW-1:0]    rd_cnt_ws,
    input  logic [OFS_W-1:0] ae_ofs,
    input  logic [OFS_W-1:0] af_ofs,
    output logic             ae_n,
    output logic             af_n
);

    localparam logic [PW-1:0] DEPTH_C = PW'(DEPTH);

    logic [PW-1:0] ae_lim;
    logic [PW-1:0] af_lim;
    logic [PW-1:0] occ_rd;
    logic [PW-1:0] space_wr;
    logic [PW-1:0] occ_now;
    logic [PW-1:0] space_now;
    logic          ae_reg_n;
    logic          af_reg_n;

    assign ae_lim    = PW'(ae_ofs);
    assign af_lim    = PW'(af_ofs);
    assign occ_rd    = wr_cnt_rs - rd_count;
    assign space_wr  = DEPTH_C - (wr_count - rd_cnt_ws);
    assign occ_now   = wr_count - rd_count;
    assign space_now = DEPTH_C - occ_now;

    always_ff @(posedge rclk or posedge rst) begin
        if (rst) begin
            ae_reg_n <= 1'b0;
        end else begin
            ae_reg_n <= !(occ_rd <= ae_lim);
        end
    end

    always_ff @(posedge wclk or posedge rst) begin
        if (rst) begin
            af_reg_n <= 1'b1;
        end else begin
            af_reg_n <= !(space_wr <= af_lim);
        end
    end

    always_comb begin
        if (sync_mode) begin
            ae_n = ae_reg_n;
            af_n = af_reg_n;
        end else begin
            ae_n = !(occ_now <= ae_lim);
            af_n = !(space_now <= af_lim);
        end
    end

endmodule

// File: rtl/pflag_unit.sv
module pflag_unit
    import pflag_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              mrst,
    input  logic              prst,
    input  logic              cfg_sync_flags,
    input  logic              cfg_narrow_in,
    input  logic              cfg_par_strip,
    input  logic [2:0]        cfg_dflt_sel,
    input  logic              prog_ld,
    input  logic              prog_wen,
    input  logic              prog_sen,
    input  logic              prog_sdata,
    input  logic [17:0]       prog_data,
    input  logic [PW-1:0]     wr_count,
    input  logic [PW-1:0]     rd_count,
    output logic              ae_n,
    output logic              af_n
);

    localparam int OFS_W = AW;

    pflag_cfg_t       cfg_pins;
    pflag_cfg_t       cfg_q;
    logic [OFS_W-1:0] ae_ofs;
    logic [OFS_W-1:0] af_ofs;
    seq_state_e       seq_q;
    logic             any_rst;
    logic             sync_mode_q;
    logic [PW-1:0]    wr_cnt_rs;
    logic [PW-1:0]    rd_cnt_ws;

    assign any_rst     = mrst | prst;
    assign sync_mode_q = cfg_q.sync_mode;
    assign cfg_pins    = '{sync_mode: cfg_sync_flags,
                           narrow_in: cfg_narrow_in,
                           par_strip: cfg_par_strip};

    pflag_offset_prog #(.OFS_W(OFS_W)) i_prog (
        .wclk     (wclk),
        .mrst     (mrst),
        .prst     (prst),
        .cfg_pins (cfg_pins),
        .dflt_sel (cfg_dflt_sel),
        .ld       (prog_ld),
        .wen      (prog_wen),
        .sen      (prog_sen),
        .sdata    (prog_sdata),
        .pdata    (prog_data),
        .cfg_q    (cfg_q),
        .ae_ofs   (ae_ofs),
        .af_ofs   (af_ofs),
        .seq_q    (seq_q)
    );

    pflag_count_sync #(.PW(PW)) i_wr_to_rd (
        .src_clk   (wclk),
        .dst_clk   (rclk),
        .rst       (any_rst),
        .src_count (wr_count),
        .dst_count (wr_cnt_rs)
    );

    pflag_count_sync #(.PW(PW)) i_rd_to_wr (
        .src_clk   (rclk),
        .dst_clk   (wclk),
        .rst       (any_rst),
        .src_count (rd_count),
        .dst_count (rd_cnt_ws)
    );

    pflag_flag_gen #(.PW(PW), .OFS_W(OFS_W), .DEPTH(DEPTH)) i_flags (
        .wclk      (wclk),
        .rclk      (rclk),
        .rst       (any_rst),
        .sync_mode (sync_mode_q),
        .wr_count  (wr_count),
        .rd_count  (rd_count),
        .wr_cnt_rs (wr_cnt_rs),
        .rd_cnt_ws (rd_cnt_ws),
        .ae_ofs    (ae_ofs),
        .af_ofs    (af_ofs),
        .ae_n      (ae_n),
        .af_n      (af_n)
    );

endmodule

// File: rtl/pflag_unit_chk.sv
module pflag_unit_chk
    import pflag_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input logic          wclk,
    input logic          rclk,
    input logic          mrst,
    input logic          prst,
    input logic          prog_ld,
    input logic [PW-1:0] wr_count,
    input logic [PW-1:0] rd_count,
    input logic          ae_n,
    input logic          af_n,
    input logic [AW-1:0] ae_ofs,
    input logic [AW-1:0] af_ofs,
    input seq_state_e    seq_q,
    input logic          sync_mode_q
);

    localparam logic [PW-1:0] DEPTH_C = PW'(DEPTH);

    // R1
    preset_equal_chk: assert property (@(posedge wclk) disable iff (prst)
        mrst |=> (ae_ofs == af_ofs));

    // R11
    prst_keeps_ofs_chk: assert property (@(posedge wclk) disable iff (mrst)
        (prst && $past(prst)) |-> ($stable(ae_ofs) && $stable(af_ofs)));

    // R9
    seq_restart_chk: assert property (@(posedge wclk) disable iff (mrst || prst)
        !prog_ld |=> (seq_q == SEQ_AE_LO));

    // R5
    async_empty_chk: assert property (@(posedge rclk) disable iff (mrst || prst)
        (!sync_mode_q && (wr_count == rd_count)) |-> !ae_n);

    // R5
    async_full_chk: assert property (@(posedge wclk) disable iff (mrst || prst)
        (!sync_mode_q && (PW'(wr_count - rd_count) == DEPTH_C)) |-> !af_n);

endmodule

bind pflag_unit pflag_unit_chk #(.DEPTH(DEPTH)) i_pflag_unit_chk (
    .wclk        (wclk),
    .rclk        (rclk),
    .mrst        (mrst),
    .prst        (prst),
    .prog_ld     (prog_ld),
    .wr_count    (wr_count),
    .rd_count    (rd_count),
    .ae_n        (ae_n),
    .af_n        (af_n),
    .ae_ofs      (ae_ofs),
    .af_ofs      (af_ofs),
    .seq_q       (seq_q),
    .sync_mode_q (sync_mode_q)
);

// File: tb/test_pflag_unit.sv
`timescale 1ns/1ps
module test_pflag_unit;

    localparam int DEPTH = 1024;
    localparam int PW    = 11;

    logic        wclk = 1'b0;
    logic        rclk = 1'b0;
    logic        mrst = 1'b1;
    logic        prst = 1'b0;
    logic        cfg_sync_flags = 1'b1;
    logic        cfg_narrow_in = 1'b0;
    logic        cfg_par_strip = 1'b1;
    logic [2:0]  cfg_dflt_sel = 3'd0;
    logic        prog_ld = 1'b0;
    logic        prog_wen = 1'b0;
    logic        prog_sen = 1'b0;
    logic        prog_sdata = 1'b0;
    logic [17:0] prog_data = '0;
    logic [PW-1:0] wr_count = '0;
    logic [PW-1:0] rd_count = '0;
    logic        ae_n;
    logic        af_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    int m_ae   = 7;
    int m_af   = 7;

    typedef struct {
        logic  ae;
        logic  af;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always #5 wclk = ~wclk;
    always #7 rclk = ~rclk;

    pflag_unit #(.DEPTH(DEPTH)) i_pflag_unit (
        .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst),
        .cfg_sync_flags(cfg_sync_flags), .cfg_narrow_in(cfg_narrow_in),
        .cfg_par_strip(cfg_par_strip), .cfg_dflt_sel(cfg_dflt_sel),
        .prog_ld(prog_ld), .prog_wen(prog_wen), .prog_sen(prog_sen),
        .prog_sdata(prog_sdata), .prog_data(prog_data),
        .wr_count(wr_count), .rd_count(rd_count),
        .ae_n(ae_n), .af_n(af_n)
    );

    // scoreboard monitor
    always @(negedge wclk) begin
        if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            n_chk++;
            if (ae_n !== it.ae || af_n !== it.af) begin
                n_fail++;
                $display("FAIL %s: ae_n,af_n = %b,%b expected %b,%b (wr=%0d rd=%0d)",
                         it.tag, ae_n, af_n, it.ae, it.af, wr_count, rd_count);
            end
        end
    end

    task automatic push_exp(input logic ae, input logic af, input string tag);
        exp_t it;
        it.ae = ae; it.af = af; it.tag = tag;
        exp_q.push_back(it);
        while (exp_q.size() != 0) @(posedge wclk);
    endtask

    task automatic expect_model(input string tag);
        int occ;
        occ = int'(wr_count) - int'(rd_count);
        push_exp(!(occ <= m_ae), !((DEPTH - occ) <= m_af), tag);
    endtask

    task automatic check_now(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: flag = %b expected %b", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (12) @(posedge wclk);
    endtask

    task automatic set_counts(input int w, input int r);
        @(negedge wclk) wr_count = PW'(w);
        @(negedge rclk) rd_count = PW'(r);
        settle();
    endtask

    task automatic do_mrst(input logic sm, input logic nw, input logic ps, input logic [2:0] sel);
        @(negedge wclk);
        cfg_sync_flags = sm; cfg_narrow_in = nw; cfg_par_strip = ps; cfg_dflt_sel = sel;
        mrst = 1'b1; wr_count = '0; rd_count = '0;
        repeat (4) @(posedge wclk);
        @(negedge wclk) mrst = 1'b0;
        m_ae = (8 << sel) - 1;
        m_af = m_ae;
        settle();
    endtask

    task automatic ld_on();
        @(negedge wclk) prog_ld = 1'b1;
    endtask

    task automatic ld_off();
        @(negedge wclk) prog_ld = 1'b0;
    endtask

    task automatic pword(input logic [17:0] d);
        @(negedge wclk) begin prog_ld = 1'b1; prog_wen = 1'b1; prog_data = d; end
        @(negedge wclk) prog_wen = 1'b0;
    endtask

    task automatic serial_load(input int ae_v, input int af_v);
        for (int i = 0; i < 20; i++) begin
            @(negedge wclk) begin
                prog_ld = 1'b1; prog_sen = 1'b1;
                prog_sdata = (i < 10) ? 1'((ae_v >> i) & 1) : 1'((af_v >> (i - 10)) & 1);
            end
        end
        @(negedge wclk) prog_sen = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge wclk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // A: sync mode, 18-bit, stripping, preset 7
        do_mrst(1'b1, 1'b0, 1'b1, 3'd0);
        push_exp(1'b0, 1'b1, "R1 reset flags");
        set_counts(7, 0);    expect_model("R2 occ=7 at threshold");
        set_counts(8, 0);    expect_model("R2 occ=8 above threshold");
        set_counts(1017, 0); expect_model("R3 free=7 at threshold");
        set_counts(1016, 0); expect_model("R3 free=8");
        set_counts(1037, 20); expect_model("R3 free=7 nonzero read count");
        set_counts(8, 0);
        @(negedge wclk) wr_count = PW'(7);
        #1 check_now(ae_n, 1'b1, "R4 sync ae holds before edges");
        settle(); expect_model("R4 sync ae after edges");

        // B: parallel load with parity stripping
        ld_on(); pword(18'h00114); pword(18'h0021E); ld_off();
        m_ae = 20; m_af = 286;
        set_counts(20, 0);  expect_model("R6 ae=20 bit8 dropped");
        set_counts(21, 0);  expect_model("R6 ae=20 edge");
        set_counts(738, 0); expect_model("R6 af=286 bit9 mapped");
        set_counts(737, 0); expect_model("R6 af=286 edge");

        // C: no stripping, preset 31, restart of sequence
        do_mrst(1'b1, 1'b0, 1'b0, 3'd2);
        set_counts(31, 0); expect_model("R1 preset 31");
        set_counts(32, 0); expect_model("R1 preset 31 edge");
        ld_on(); pword(18'h00050); ld_off();
        ld_on(); pword(18'h30105); pword(18'h00040); ld_off();
        m_ae = 261; m_af = 64;
        set_counts(261, 0); expect_model("R7 ae=261 bit8 kept");
        set_counts(262, 0); expect_model("R7 ae=261 edge bits16-17 ignored");
        set_counts(960, 0); expect_model("R9 af=64 after restart");
        set_counts(959, 0); expect_model("R9 af=64 edge");
        set_counts(0, 0);
        @(negedge wclk) prst = 1'b1;
        repeat (3) @(posedge wclk);
        @(negedge wclk) prst = 1'b0;
        settle();
        push_exp(1'b0, 1'b1, "R11 flags after partial reset");
        set_counts(262, 0); expect_model("R11 ae kept 261");
        set_counts(261, 0); expect_model("R11 ae kept 261 edge");
        set_counts(960, 0); expect_model("R11 af kept 64");
        // R12: mode pin change after reset has no effect
        cfg_sync_flags = 1'b0;
        @(negedge wclk) wr_count = PW'(959);
        #1 check_now(af_n, 1'b0, "R12 sync mode retained");
        settle(); expect_model("R12 sync af after edge");

        // D: 9-bit input, preset 1023
        do_mrst(1'b1, 1'b1, 1'b1, 3'd7);
        set_counts(1023, 0); expect_model("R1 preset 1023");
        ld_on();
        pword(18'h3FF90); pword(18'h3FE00); pword(18'h00064); pword(18'h00001);
        ld_off();
        m_ae = 400; m_af = 612;
        set_counts(400, 0); expect_model("R8 ae=400 two words");
        set_counts(401, 0); expect_model("R8 ae=400 edge");
        set_counts(412, 0); expect_model("R8 af=612 two words");
        set_counts(411, 0); expect_model("R8 af=612 edge");
        serial_load(5, 9); ld_off();
        m_ae = 5; m_af = 9;
        set_counts(5, 0);    expect_model("R10 serial ae=5");
        set_counts(6, 0);    expect_model("R10 serial ae=5 edge");
        set_counts(1015, 0); expect_model("R10 serial af=9");
        set_counts(1014, 0); expect_model("R10 serial af=9 edge");

        // E: asynchronous mode, preset 7
        do_mrst(1'b0, 1'b0, 1'b0, 3'd0);
        cfg_sync_flags = 1'b1;
        set_counts(8, 0); expect_model("R5 async baseline");
        @(negedge rclk) rd_count = PW'(1);
        #1 check_now(ae_n, 1'b0, "R5 async ae low on read");
        @(negedge wclk) wr_count = PW'(9);
        #1 check_now(ae_n, 1'b1, "R5 async ae high on write");
        @(negedge wclk) wr_count = PW'(1018);
        #1 check_now(af_n, 1'b0, "R5 async af low on write");
        @(negedge rclk) rd_count = PW'(2);
        #1 check_now(af_n, 1'b1, "R5 async af high on read");

        settle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule